// File: doc/BRIEF.md
# SD Command Response Frame Checker

This block sits behind the command line of an SD host. Once a command has gone out, the command sequencer pulses a start input. It supplies the command index it sent and picks one of two response latency windows. The checker then watches the sampled command line. It uses only the cycles in which a bit-enable strobe is high. It waits for the card's start bit, shifts in the rest of a 48-bit short response, and checks every field.

Each fault class is reported on its own flag: a bad index echo, a wrong direction bit, a CRC7 mismatch, a missing stop bit, or a response that never started. The flags and the 32-bit argument appear together with a single-cycle completion pulse. They then hold their values until the next start pulse.

Top module: `sd_resp_checker`

## Requirements
- R1: The frame is taken MSB first as 48 bits: start bit 0, direction bit, 6-bit index, 32-bit argument, 7-bit CRC, stop bit. `argOut` shows the received argument from the completion pulse onward.
- R2: `idxErr` is 1 when the received 6-bit index differs from `expIndex`, which is sampled at the start pulse.
- R3: `dirErr` is 1 when the direction bit is not 0, where 0 means card to host.
- R4: `crcErr` is 1 when the received 7-bit CRC differs from the CRC7 of the first 40 frame bits. The CRC uses polynomial x^7+x^3+1, starts at zero, and takes the MSB first.
- R5: `endErr` is 1 when the last frame bit is not 1.
- R6: While waiting, the limit is 5 strobes when `longLatency` is 0 and 64 strobes when it is 1, taken at the start pulse. A 0 on any strobe up to the limit-th starts the frame. If the limit-th strobe still samples 1, `timeoutErr` is set and the four frame flags stay 0.
- R7: Only cycles with `bitEn` high are sampled. The start bit is the first sampled 0 after the start pulse. Line values in cycles without the strobe have no effect.
- R8: `respDone` is high for exactly one cycle, the cycle after the strobe that carried the stop bit or the timeout sample. All flags and `argOut` hold until the next start pulse. A start pulse clears them in the following cycle and restarts reception, even in the middle of a frame.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle pulse: a command was sent, await its response |
| expIndex | input | 6 | Index of the command sent |
| longLatency | input | 1 | Latency window select: 0 = 5 strobes, 1 = 64 strobes |
| cmdLine | input | 1 | Sampled command line level |
| bitEn | input | 1 | Bit strobe: `cmdLine` is valid this cycle |
| argOut | output | 32 | Received argument |
| idxErr | output | 1 | Index mismatch |
| dirErr | output | 1 | Direction bit not card to host |
| crcErr | output | 1 | CRC7 mismatch |
| endErr | output | 1 | Stop bit missing |
| timeoutErr | output | 1 | No start bit within the latency window |
| respDone | output | 1 | Completion pulse |

## Verification
Every result appears in the clock cycle right after the posedge at which the final strobe is sampled. For a frame, that strobe carries the stop bit; for a timeout, it is the limit-th idle sample. The bench drives each strobe for exactly one cycle from a falling edge and sends the final strobe with no idle gap after it. It then samples `respDone`, the flags and `argOut` at the very next falling edge. One falling edge later it checks that the pulse has dropped and that the results still hold. Strobe-free gap cycles with random line levels are placed between all other bits, so the due cycle is always counted from the final strobe and never from the start pulse.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam int LAT_SHORT = 5;
  localparam int LAT_LONG  = 64;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef struct packed {
    logic clear;
    logic waitStep;
    logic shiftBit;
    logic finishFrame;
    logic finishTimeout;
  } ctrlStrobe_t;
endpackage

// File: rtl/sd_resp_ctrl.sv
module sd_resp_ctrl
  import sd_resp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        cmdLine,
  input  logic        bitEn,
  input  logic        waitLast,
  input  logic        lastBit,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RECV} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (startPulse) begin
      strobe.clear = 1'b1;
      stateNext    = ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: if (bitEn) begin
          if (!cmdLine) begin
            stateNext = ST_RECV;
          end else if (waitLast) begin
            strobe.finishTimeout = 1'b1;
            stateNext            = ST_IDLE;
          end else begin
            strobe.waitStep = 1'b1;
          end
        end
        ST_RECV: if (bitEn) begin
          strobe.shiftBit = 1'b1;
          if (lastBit) begin
            strobe.finishFrame = 1'b1;
            stateNext          = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/sd_resp_datapath.sv
module sd_resp_datapath
  import sd_resp_pkg::*;
#(
  parameter int IdxW     = IDX_W,
  parameter int ArgW     = ARG_W,
  parameter int CrcW     = CRC_W,
  parameter int LatShort = LAT_SHORT,
  parameter int LatLong  = LAT_LONG
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic            cmdLine,
  input  logic [IdxW-1:0] expIndex,
  input  logic            longLatency,
  output logic            waitLast,
  output logic            lastBit,
  output logic [ArgW-1:0] argOut,
  output logic            idxErr,
  output logic            dirErr,
  output logic            crcErr,
  output logic            endErr,
  output logic            timeoutErr,
  output logic            respDone
);
  // body = direction + index + argument + crc; the stop bit is taken live
  localparam int BODY_W   = 1 + IdxW + ArgW + CrcW;
  localparam int CRC_SPAN = 1 + IdxW + ArgW;
  localparam int CNT_W    = $clog2(BODY_W + 1);
  localparam int WAIT_W   = $clog2(LatLong + 1);

  logic [BODY_W-1:0] bodySr;
  logic [CrcW-1:0]   crcAcc, crcNext;
  logic [CNT_W-1:0]  bitCnt;
  logic [WAIT_W-1:0] waitCnt, limitReg;
  logic [IdxW-1:0]   expIdxReg;

  logic            rxDir;
  logic [IdxW-1:0] rxIdx;
  logic [ArgW-1:0] rxArg;
  logic [CrcW-1:0] rxCrc;
  logic            fb;

  assign rxDir = bodySr[BODY_W-1];
  assign rxIdx = bodySr[BODY_W-2 -: IdxW];
  assign rxArg = bodySr[CrcW +: ArgW];
  assign rxCrc = bodySr[CrcW-1:0];

  // serial CRC7 step; the leading start bit is 0 and leaves a zero seed unchanged
  always_comb begin
    fb      = crcAcc[CrcW-1] ^ cmdLine;
    crcNext = {crcAcc[CrcW-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign waitLast = (waitCnt == limitReg - WAIT_W'(1));
  assign lastBit  = (bitCnt == CNT_W'(BODY_W));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bodySr     <= '0;
      crcAcc     <= '0;
      bitCnt     <= '0;
      waitCnt    <= '0;
      limitReg   <= WAIT_W'(LatShort);
      expIdxReg  <= '0;
      argOut     <= '0;
      idxErr     <= 1'b0;
      dirErr     <= 1'b0;
      crcErr     <= 1'b0;
      endErr     <= 1'b0;
      timeoutErr <= 1'b0;
      respDone   <= 1'b0;
    end else begin
      respDone <= strobe.finishFrame | strobe.finishTimeout;
      if (strobe.clear) begin
        crcAcc     <= '0;
        bitCnt     <= '0;
        waitCnt    <= '0;
        limitReg   <= longLatency ? WAIT_W'(LatLong) : WAIT_W'(LatShort);
        expIdxReg  <= expIndex;
        argOut     <= '0;
        idxErr     <= 1'b0;
        dirErr     <= 1'b0;
        crcErr     <= 1'b0;
        endErr     <= 1'b0;
        timeoutErr <= 1'b0;
      end
      if (strobe.waitStep) waitCnt <= waitCnt + WAIT_W'(1);
      if (strobe.shiftBit) begin
        bodySr <= {bodySr[BODY_W-2:0], cmdLine};
        bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt < CNT_W'(CRC_SPAN)) crcAcc <= crcNext;
      end
      if (strobe.finishFrame) begin
        argOut <= rxArg;
        idxErr <= (rxIdx != expIdxReg);
        dirErr <= (rxDir != 1'b0);
        crcErr <= (rxCrc != crcAcc);
        endErr <= (cmdLine != 1'b1);
      end
      if (strobe.finishTimeout) timeoutErr <= 1'b1;
    end
  end
endmodule

// File: rtl/sd_resp_checker.sv
module sd_resp_checker
  import sd_resp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [IDX_W-1:0] expIndex,
  input  logic             longLatency,
  input  logic             cmdLine,
  input  logic             bitEn,
  output logic [ARG_W-1:0] argOut,
  output logic             idxErr,
  output logic             dirErr,
  output logic             crcErr,
  output logic             endErr,
  output logic             timeoutErr,
  output logic             respDone
);
  ctrlStrobe_t strobe;
  logic        waitLast, lastBit;

  sd_resp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmdLine(cmdLine),
    .bitEn(bitEn), .waitLast(waitLast), .lastBit(lastBit), .strobe(strobe)
  );

  sd_resp_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdLine(cmdLine),
    .expIndex(expIndex), .longLatency(longLatency), .waitLast(waitLast),
    .lastBit(lastBit), .argOut(argOut), .idxErr(idxErr), .dirErr(dirErr),
    .crcErr(crcErr), .endErr(endErr), .timeoutErr(timeoutErr),
    .respDone(respDone)
  );
endmodule

// File: rtl/sd_resp_checker_sva.sv
module sd_resp_checker_sva
  import sd_resp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             bitEn,
  input logic [ARG_W-1:0] argOut,
  input logic             idxErr,
  input logic             dirErr,
  input logic             crcErr,
  input logic             endErr,
  input logic             timeoutErr,
  input logic             respDone
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone); // R8
  AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !(idxErr || dirErr || crcErr || endErr)); // R6
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> (respDone || ($stable(argOut) && $stable(idxErr) && $stable(dirErr)
                     && $stable(crcErr) && $stable(endErr) && $stable(timeoutErr)))); // R8
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> $past(bitEn)); // R7
  AST_DONE_NOT_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> !$past(startPulse)); // R8
endmodule

bind sd_resp_checker sd_resp_checker_sva u_sva (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .bitEn(bitEn),
  .argOut(argOut), .idxErr(idxErr), .dirErr(dirErr), .crcErr(crcErr),
  .endErr(endErr), .timeoutErr(timeoutErr), .respDone(respDone)
);

// File: tb/sd_resp_checker_bench.sv
module sd_resp_checker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [5:0]  expIndex = '0;
  logic        longLatency = 1'b0;
  logic        cmdLine = 1'b1;
  logic        bitEn = 1'b0;
  logic [31:0] argOut;
  logic        idxErr, dirErr, crcErr, endErr, timeoutErr, respDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sd_resp_checker u_sd_resp_checker (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .expIndex(expIndex),
    .longLatency(longLatency), .cmdLine(cmdLine), .bitEn(bitEn), .argOut(argOut),
    .idxErr(idxErr), .dirErr(dirErr), .crcErr(crcErr), .endErr(endErr),
    .timeoutErr(timeoutErr), .respDone(respDone)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic       f;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      f = c[6] ^ d[i];
      c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic int limitOf(input logic lng);
    return lng ? 64 : 5;
  endfunction

  task automatic sendBit(input logic b, input int gap);
    @(negedge clk);
    cmdLine = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    for (int g = 0; g < gap; g++) begin
      cmdLine = 1'($urandom % 2);
      @(negedge clk);
    end
  endtask

  task automatic startCmd(input logic [5:0] idx, input logic lng);
    @(negedge clk);
    expIndex = idx;
    longLatency = lng;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cmdLine = 1'b1;
    expIndex = ~idx;
    longLatency = ~lng;
  endtask

  task automatic runFrame(input logic [5:0] expIdx, input logic lng, input int lead,
                          input logic dir, input logic [5:0] rxIdx, input logic [31:0] arg,
                          input logic crcBad, input logic endB);
    logic [39:0] head;
    logic [6:0]  c;
    logic [47:0] frame;
    startCmd(expIdx, lng);
    for (int k = 0; k < lead; k++) sendBit(1'b1, int'($urandom % 3));
    head = {1'b0, dir, rxIdx, arg};
    c = crc7(head);
    if (crcBad) c = c ^ (7'd1 << ($urandom % 7));
    frame = {head, c, endB};
    for (int i = 47; i >= 1; i--) sendBit(frame[i], int'($urandom % 3));
    check("R7", "no completion before stop bit", 32'(respDone), 32'd0);
    sendBit(frame[0], 0);
    check("R8", "done pulse", 32'(respDone), 32'd1);
    check("R1", "argument", argOut, arg);
    check("R2", "index error", 32'(idxErr), 32'(rxIdx != expIdx));
    check("R3", "direction error", 32'(dirErr), 32'(dir != 1'b0));
    check("R4", "crc error", 32'(crcErr), 32'(crcBad));
    check("R5", "stop bit error", 32'(endErr), 32'(endB != 1'b1));
    check("R6", "no timeout on frame", 32'(timeoutErr), 32'd0);
    @(negedge clk);
    check("R8", "done drops", 32'(respDone), 32'd0);
    check("R8", "argument held", argOut, arg);
    check("R8", "crc flag held", 32'(crcErr), 32'(crcBad));
  endtask

  task automatic runTimeout(input logic lng);
    int lim;
    lim = limitOf(lng);
    startCmd(6'h11, lng);
    for (int k = 0; k < lim - 1; k++) sendBit(1'b1, int'($urandom % 3));
    check("R6", "no early timeout", 32'(respDone), 32'd0);
    sendBit(1'b1, 0);
    check("R6", "timeout done", 32'(respDone), 32'd1);
    check("R6", "timeout flag", 32'(timeoutErr), 32'd1);
    check("R6", "frame flags quiet",
          32'({idxErr, dirErr, crcErr, endErr}), 32'd0);
    @(negedge clk);
    check("R8", "timeout done drops", 32'(respDone), 32'd0);
    check("R8", "timeout held", 32'(timeoutErr), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9", "reset outputs",
          32'({idxErr, dirErr, crcErr, endErr, timeoutErr, respDone}), 32'd0);
    check("R9", "reset argument", argOut, 32'd0);
    rstN = 1'b1;

    runFrame(6'h08, 1'b0, 0, 1'b0, 6'h08, 32'hDEADBEEF, 1'b0, 1'b1);
    runFrame(6'h37, 1'b0, 4, 1'b0, 6'h37, 32'h00000000, 1'b0, 1'b1);  // R6 boundary
    runTimeout(1'b0);
    runTimeout(1'b1);
    runFrame(6'h2A, 1'b1, 63, 1'b0, 6'h2A, 32'hFFFFFFFF, 1'b0, 1'b1); // R6 boundary
    runFrame(6'h05, 1'b0, 1, 1'b0, 6'h06, 32'h12345678, 1'b0, 1'b1);  // R2
    runFrame(6'h05, 1'b0, 2, 1'b1, 6'h05, 32'h12345678, 1'b0, 1'b1);  // R3
    runFrame(6'h05, 1'b0, 0, 1'b0, 6'h05, 32'h12345678, 1'b1, 1'b1);  // R4
    runFrame(6'h05, 1'b0, 3, 1'b0, 6'h05, 32'h12345678, 1'b0, 1'b0);  // R5

    // R8: a start pulse clears held flags
    startCmd(6'h01, 1'b0);
    check("R8", "flags cleared by start",
          32'({idxErr, dirErr, crcErr, endErr, timeoutErr}), 32'd0);
    check("R8", "argument cleared by start", argOut, 32'd0);
    // R8: restart mid-frame, then a full frame must check cleanly
    sendBit(1'b0, 0);
    for (int k = 0; k < 20; k++) sendBit(1'($urandom % 2), 1);
    runFrame(6'h3F, 1'b0, 2, 1'b0, 6'h3F, 32'hA5A55A5A, 1'b0, 1'b1);

    for (int n = 0; n < 30; n++) begin
      logic       lng, dir, crcBad, endB;
      logic [5:0] e, r;
      lng    = 1'($urandom % 2);
      e      = 6'($urandom);
      r      = (($urandom % 4) == 0) ? 6'($urandom) : e;
      dir    = (($urandom % 4) == 0);
      crcBad = (($urandom % 4) == 0);
      endB   = (($urandom % 4) != 0);
      runFrame(e, lng, int'($urandom % limitOf(lng)), dir, r, $urandom, crcBad, endB);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule